// File: doc/BRIEF.md
# Programmable Display Sync Counter Bank

This block holds eight programmable waveform generators, numbered 1 to 8. Together they produce the timing of a raster display: an internal line strobe, an internal frame strobe, horizontal and vertical sync pins, a line-active enable and a pixel-active enable. Each generator counts events from a source that software selects. The source is either the pixel clock (the block clock, one event per cycle) or the end-of-period strobe of another generator. Generators can therefore be chained: a line counter feeds a frame counter, a frame counter clears a line-active window, and that window clears a pixel-active window.

Each generator has a run period, a start offset, a repeat limit and a clear source. It can also drive a pulse on its pin between two edge positions, given in half-pixel steps and counted on a trigger source that is selected separately. Configuration is loaded through a single write port. A global word holds the bank enable, one polarity bit per pin and an inversion bit for the outgoing pixel clock.

Top module: `sync_counter_bank`

## Requirements
- R1: After reset, and from the second clock edge after the enable bit is written 0, every strobe is 0 and every pin sits at its polarity bit. Disabling resets all counters, so the next enable starts every generator from its initial state.
- R2: A write with `cfg_addr = {gen, word}` (gen = generator number - 1 in bits 4:2, word in bits 1:0) loads one of the following words.
  - word 0: run count [11:0], run source [15:12], offset count [27:16], offset source [31:28].
  - word 1: repeat count [11:0], clear source [15:12], trigger source [19:16], pulse enable [20].
  - word 2: up edge [9:0], down edge [25:16].
  - word 3, for any gen: enable [0], pin polarity [15:8], clock inversion [16].
  - A write takes effect from the next clock edge.
- R3: A generator in its run phase emits a one-cycle strobe on every (run count + 1)-th event of its run source.
- R4: After an enable, a clear or reset, a generator counts offset-count events of its offset source before it counts any run event. A run event in the cycle that completes the offset is not counted.
- R5: With a nonzero repeat count, a generator stops after that many strobes and stays silent until its clear source fires. A repeat count of 0 runs the generator continuously.
- R6: Clear source code 0 never clears. Code 1 clears on every cycle. Codes 2 to 9 clear on the strobe of generator (code - 1). A clear zeroes all of that generator's counters and wins over every other event in that cycle.
- R7: Source codes for run, offset and trigger are 0 = none, 1 = pixel clock, 2 to 9 = strobe of generator (code - 1). A chained strobe is seen as an event one cycle after it appears at the port.
- R8: With pulse enable set, the generator keeps a trigger-event count k. The count restarts at 0 on each strobe, on a clear and on enable, and saturates at 1023. The pulse is high while up <= 2k < down. The pulse is 0 when pulse enable is clear.
- R9: pin[i] is the generator's pulse XOR polarity bit i. pclk_out is the clock XOR the inversion bit.
- R10: A non-interlaced frame (line counter, sync pulses, line-active gated by the vertical strobe, pixel-active gated by line-active) gives one line strobe per h_total clocks. Within each active line it gives hactive pixel strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Generator index and word select |
| cfg_wdata | input | 32 | Configuration write data |
| strobe | output | 8 | End-of-period strobe of each generator |
| pin | output | 8 | Pulse output of each generator after polarity |
| pclk_out | output | 1 | Outgoing pixel clock, optionally inverted |

## Verification
A wrong counter value in one generator shifts its strobe by at least one cycle. Any generator chained from it then shifts too, one cycle later per link. The bench compares all strobes and pins on every cycle, so a fault shows up on the first cycle in which the faulty generator should have emitted or held back a strobe. Mistakes in the repeat limit or the clear logic show up within one frame as extra or missing line-active or pixel-active strobes. A pulse-window error shows up on the first line as a pin that is wider, narrower or shifted.

// File: rtl/sync_bank_pkg.sv
package sync_bank_pkg;
  parameter int NGEN   = 8;
  parameter int CNT_W  = 12;
  parameter int EDGE_W = 10;
  parameter int SRC_W  = 4;
  parameter int DATA_W = 32;
  localparam int ADDR_W = $clog2(NGEN) + 2;

  // field positions inside the configuration words
  localparam int F_RUN  = 0;
  localparam int F_RSRC = 12;
  localparam int F_OFF  = 16;
  localparam int F_OSRC = 28;
  localparam int F_REP  = 0;
  localparam int F_CLR  = 12;
  localparam int F_TRIG = 16;
  localparam int F_PEN  = 20;
  localparam int F_UP   = 0;
  localparam int F_DOWN = 16;
  localparam int F_EN   = 0;
  localparam int F_POL  = 8;
  localparam int F_INV  = 16;

  typedef struct packed {
    logic [CNT_W-1:0]  run_cnt;
    logic [SRC_W-1:0]  run_src;
    logic [CNT_W-1:0]  off_cnt;
    logic [SRC_W-1:0]  off_src;
    logic [CNT_W-1:0]  rep_cnt;
    logic [SRC_W-1:0]  clr_src;
    logic [SRC_W-1:0]  trig_src;
    logic              pulse_en;
    logic [EDGE_W-1:0] up_pos;
    logic [EDGE_W-1:0] down_pos;
  } gen_cfg_t;

  // event decode: 0 none, 1 pixel clock, 2.. strobe of generator (code-1)
  function automatic logic src_event(input logic [SRC_W-1:0] code,
                                     input logic [NGEN-1:0] strobes);
    int idx;
    idx = int'(code) - 2;
    if (code == '0) return 1'b0;
    if (code == SRC_W'(1)) return 1'b1;
    if (idx < NGEN) return strobes[idx];
    return 1'b0;
  endfunction

  // half-step window: high while up <= 2k < down
  function automatic logic in_window(input logic [EDGE_W-1:0] k,
                                     input logic [EDGE_W-1:0] up,
                                     input logic [EDGE_W-1:0] down);
    logic [EDGE_W:0] twice;
    twice = {k, 1'b0};
    return (twice >= {1'b0, up}) && (twice < {1'b0, down});
  endfunction
endpackage

// File: rtl/sync_bank_regs.sv
module sync_bank_regs
  import sync_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output gen_cfg_t          cfg_o [NGEN],
  output logic              glb_en,
  output logic [NGEN-1:0]   pin_pol,
  output logic              pclk_inv
);
  localparam int GSEL_W = ADDR_W - 2;

  logic [GSEL_W-1:0] sel_gen;
  logic [1:0]        sel_word;
  logic              glb_hit;

  assign sel_gen  = addr[ADDR_W-1:2];
  assign sel_word = addr[1:0];
  assign glb_hit  = we && (sel_word == 2'd3);

  for (genvar g = 0; g < NGEN; g++) begin : g_cfg
    gen_cfg_t cfg_q;
    logic     hit;
    assign hit = we && (sel_gen == GSEL_W'(g)) && (sel_word != 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (hit) begin
        case (sel_word)
          2'd0: begin
            cfg_q.run_cnt <= wdata[F_RUN  +: CNT_W];
            cfg_q.run_src <= wdata[F_RSRC +: SRC_W];
            cfg_q.off_cnt <= wdata[F_OFF  +: CNT_W];
            cfg_q.off_src <= wdata[F_OSRC +: SRC_W];
          end
          2'd1: begin
            cfg_q.rep_cnt  <= wdata[F_REP  +: CNT_W];
            cfg_q.clr_src  <= wdata[F_CLR  +: SRC_W];
            cfg_q.trig_src <= wdata[F_TRIG +: SRC_W];
            cfg_q.pulse_en <= wdata[F_PEN];
          end
          default: begin
            cfg_q.up_pos   <= wdata[F_UP   +: EDGE_W];
            cfg_q.down_pos <= wdata[F_DOWN +: EDGE_W];
          end
        endcase
      end
    end
    assign cfg_o[g] = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      pin_pol  <= '0;
      pclk_inv <= 1'b0;
    end else if (glb_hit) begin
      glb_en   <= wdata[F_EN];
      pin_pol  <= wdata[F_POL +: NGEN];
      pclk_inv <= wdata[F_INV];
    end
  end
endmodule

// File: rtl/sync_gen.sv
module sync_gen
  import sync_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  gen_cfg_t        cfg,
  input  logic [NGEN-1:0] strobes,
  output logic            strobe_o,
  output logic            pulse_o
);
  logic [CNT_W-1:0]  ocnt_q, rcnt_q, reps_q, ocnt_n, rcnt_n, reps_n;
  logic [EDGE_W-1:0] pcnt_q, pcnt_n;
  logic              stopped_q, stopped_n, pulse_n;

  // named internal events
  logic run_ev, off_ev, clr_ev, trig_ev;
  logic offset_phase, auto_reload, period_end;

  assign run_ev       = src_event(cfg.run_src, strobes);
  assign off_ev       = src_event(cfg.off_src, strobes);
  assign clr_ev       = src_event(cfg.clr_src, strobes);
  assign trig_ev      = src_event(cfg.trig_src, strobes);
  assign offset_phase = ocnt_q < cfg.off_cnt;
  assign auto_reload  = cfg.rep_cnt == '0;
  assign period_end   = en && !clr_ev && !stopped_q && !offset_phase &&
                        run_ev && (rcnt_q == cfg.run_cnt);

  always_comb begin
    ocnt_n    = ocnt_q;
    rcnt_n    = rcnt_q;
    reps_n    = reps_q;
    stopped_n = stopped_q;
    if (!en || clr_ev) begin
      ocnt_n    = '0;
      rcnt_n    = '0;
      reps_n    = '0;
      stopped_n = 1'b0;
    end else if (!stopped_q) begin
      if (offset_phase) begin
        if (off_ev) ocnt_n = ocnt_q + 1'b1;
      end else if (run_ev) begin
        if (period_end) begin
          rcnt_n = '0;
          if (!auto_reload) begin
            reps_n = reps_q + 1'b1;
            if (reps_q + 1'b1 == cfg.rep_cnt) stopped_n = 1'b1;
          end
        end else begin
          rcnt_n = rcnt_q + 1'b1;
        end
      end
    end
    if (!en || clr_ev || period_end) pcnt_n = '0;
    else if (trig_ev && (pcnt_q != '1)) pcnt_n = pcnt_q + 1'b1;
    else pcnt_n = pcnt_q;
    pulse_n = en && cfg.pulse_en && in_window(pcnt_n, cfg.up_pos, cfg.down_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt_q    <= '0;
      rcnt_q    <= '0;
      reps_q    <= '0;
      stopped_q <= 1'b0;
      pcnt_q    <= '0;
      strobe_o  <= 1'b0;
      pulse_o   <= 1'b0;
    end else begin
      ocnt_q    <= ocnt_n;
      rcnt_q    <= rcnt_n;
      reps_q    <= reps_n;
      stopped_q <= stopped_n;
      pcnt_q    <= pcnt_n;
      strobe_o  <= period_end;
      pulse_o   <= pulse_n;
    end
  end

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !strobe_o && !pulse_o);
  assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr_ev |=> !strobe_o && rcnt_q == '0 && ocnt_q == '0 && !stopped_q);
  assert_offset_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr_ev && offset_phase |=> !strobe_o);
  assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr_ev && stopped_q |=> !strobe_o && stopped_q);
  assert_pulse_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.pulse_en |=> !pulse_o);
endmodule

// File: rtl/sync_counter_bank.sv
module sync_counter_bank
  import sync_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [NGEN-1:0]   strobe,
  output logic [NGEN-1:0]   pin,
  output logic              pclk_out
);
  gen_cfg_t        cfg_w [NGEN];
  logic            glb_en, pclk_inv;
  logic [NGEN-1:0] pin_pol, pulse_w;

  sync_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .cfg_o    (cfg_w),
    .glb_en   (glb_en),
    .pin_pol  (pin_pol),
    .pclk_inv (pclk_inv)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    sync_gen u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (glb_en),
      .cfg      (cfg_w[g]),
      .strobes  (strobe),
      .strobe_o (strobe[g]),
      .pulse_o  (pulse_w[g])
    );
  end

  assign pin      = pulse_w ^ pin_pol;
  assign pclk_out = clk ^ pclk_inv;
endmodule

// File: tb/sync_counter_bank_tb.sv
`timescale 1ns/1ps
module sync_counter_bank_tb;
  import sync_bank_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [NGEN-1:0] strobe, pin;
  logic pclk_out;

  always #5 clk = ~clk;

  sync_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .strobe(strobe), .pin(pin), .pclk_out(pclk_out)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  int m_run[NGEN], m_rsrc[NGEN], m_off[NGEN], m_osrc[NGEN], m_rep[NGEN];
  int m_clr[NGEN], m_trig[NGEN], m_pen[NGEN], m_up[NGEN], m_down[NGEN];
  int m_en = 0, m_pol = 0, m_inv = 0;
  int s_oc[NGEN], s_rc[NGEN], s_rp[NGEN], s_st[NGEN], s_pc[NGEN], s_sq[NGEN], s_pq[NGEN];
  bit [NGEN-1:0] snap;

  function automatic int ev(int code, bit [NGEN-1:0] s);
    if (code == 0) return 0;
    if (code == 1) return 1;
    if (code - 2 < NGEN) return int'(s[code-2]);
    return 0;
  endfunction

  function automatic int win(int k, int up, int down);
    return ((2 * k >= up) && (2 * k < down)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_inv = 0;
      for (int g = 0; g < NGEN; g++) begin
        m_run[g] = 0; m_rsrc[g] = 0; m_off[g] = 0; m_osrc[g] = 0; m_rep[g] = 0;
        m_clr[g] = 0; m_trig[g] = 0; m_pen[g] = 0; m_up[g] = 0; m_down[g] = 0;
        s_oc[g] = 0; s_rc[g] = 0; s_rp[g] = 0; s_st[g] = 0; s_pc[g] = 0;
        s_sq[g] = 0; s_pq[g] = 0;
      end
    end else begin
      for (int g = 0; g < NGEN; g++) snap[g] = (s_sq[g] != 0);
      for (int g = 0; g < NGEN; g++) begin
        int fin;
        fin = 0;
        if (m_en == 0) begin
          s_oc[g] = 0; s_rc[g] = 0; s_rp[g] = 0; s_st[g] = 0; s_pc[g] = 0;
          s_sq[g] = 0; s_pq[g] = 0;
        end else if (ev(m_clr[g], snap) != 0) begin
          s_oc[g] = 0; s_rc[g] = 0; s_rp[g] = 0; s_st[g] = 0; s_pc[g] = 0;
          s_sq[g] = 0; s_pq[g] = m_pen[g] * win(0, m_up[g], m_down[g]);
        end else begin
          if (s_st[g] == 0) begin
            if (s_oc[g] < m_off[g]) begin
              if (ev(m_osrc[g], snap) != 0) s_oc[g]++;
            end else if (ev(m_rsrc[g], snap) != 0) begin
              if (s_rc[g] == m_run[g]) begin
                fin = 1; s_rc[g] = 0;
                if (m_rep[g] != 0) begin
                  s_rp[g]++;
                  if (s_rp[g] == m_rep[g]) s_st[g] = 1;
                end
              end else s_rc[g]++;
            end
          end
          s_sq[g] = fin;
          if (fin != 0) s_pc[g] = 0;
          else if (ev(m_trig[g], snap) != 0 && s_pc[g] < 1023) s_pc[g]++;
          s_pq[g] = m_pen[g] * win(s_pc[g], m_up[g], m_down[g]);
        end
      end
      if (cfg_we) begin
        int g, w;
        g = int'(cfg_addr[ADDR_W-1:2]);
        w = int'(cfg_addr[1:0]);
        if (w == 3) begin
          m_en = int'(cfg_wdata[0]); m_pol = int'(cfg_wdata[15:8]); m_inv = int'(cfg_wdata[16]);
        end else if (w == 0) begin
          m_run[g] = int'(cfg_wdata[11:0]); m_rsrc[g] = int'(cfg_wdata[15:12]);
          m_off[g] = int'(cfg_wdata[27:16]); m_osrc[g] = int'(cfg_wdata[31:28]);
        end else if (w == 1) begin
          m_rep[g] = int'(cfg_wdata[11:0]); m_clr[g] = int'(cfg_wdata[15:12]);
          m_trig[g] = int'(cfg_wdata[19:16]); m_pen[g] = int'(cfg_wdata[20]);
        end else begin
          m_up[g] = int'(cfg_wdata[9:0]); m_down[g] = int'(cfg_wdata[25:16]);
        end
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [NGEN-1:0] es, ep;
      for (int g = 0; g < NGEN; g++) begin
        es[g] = (s_sq[g] != 0);
        ep[g] = (s_pq[g] != 0) ^ m_pol[g];
      end
      n_cmp++;
      if (strobe !== es || pin !== ep || pclk_out !== m_inv[0]) begin
        n_bad++;
        $display("FAIL %s: strobe/pin/pclk actual %h/%h/%b expected %h/%h/%b",
                 phase, strobe, pin, pclk_out, es, ep, m_inv[0]);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int gen, int word, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = ADDR_W'((gen << 2) | word);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] w0(int run, int rs, int off, int os);
    return 32'(run) | (32'(rs) << 12) | (32'(off) << 16) | (32'(os) << 28);
  endfunction
  function automatic logic [31:0] w1(int rep, int clr, int trig, int pen);
    return 32'(rep) | (32'(clr) << 12) | (32'(trig) << 16) | (32'(pen) << 20);
  endfunction
  function automatic logic [31:0] w2(int up, int down);
    return 32'(up) | (32'(down) << 16);
  endfunction
  function automatic logic [31:0] wg(int en, int pol, int inv);
    return 32'(en) | (32'(pol) << 8) | (32'(inv) << 16);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int c_line, c_hs, c_vs, c_vpin, c_la, c_px, c6, c7, c8, c8pin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset strobes", int'(strobe), 0);
    chk("R1 reset pins", int'(pin), 0);

    phase = "R9";
    wr(0, 3, wg(0, 8'hA5, 1));
    chk("R9 pin polarity while idle", int'(pin), 8'hA5);
    chk("R9 R2 clock inversion", int'(pclk_out), 1);

    // frame: h_total 10 (hsync 2, hbp 2, hact 4), v_total 6 (vs 1, vbp 1, vact 3)
    phase = "R10";
    wr(0, 0, w0(9, 1, 0, 0));                         // line strobe
    wr(1, 0, w0(9, 1, 0, 0)); wr(1, 1, w1(0, 0, 1, 1)); wr(1, 2, w2(0, 4));  // hsync
    wr(2, 0, w0(5, 2, 0, 0)); wr(2, 1, w1(0, 0, 2, 1)); wr(2, 2, w2(0, 2));  // vsync
    wr(3, 0, w0(0, 2, 2, 2)); wr(3, 1, w1(3, 4, 0, 0));                      // line active
    wr(4, 0, w0(0, 1, 4, 1)); wr(4, 1, w1(4, 5, 0, 0));                      // pixel active
    wr(0, 3, wg(1, 0, 0));
    repeat (200) @(negedge clk);
    c_line = 0; c_hs = 0; c_vs = 0; c_vpin = 0; c_la = 0; c_px = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      c_line += int'(strobe[0]); c_hs += int'(pin[1]); c_vs += int'(strobe[2]);
      c_vpin += int'(pin[2]); c_la += int'(strobe[3]); c_px += int'(strobe[4]);
    end
    chk("R3 line strobes per 120 clocks", c_line, 12);
    chk("R8 hsync high clocks", c_hs, 24);
    chk("R7 frame strobes chained", c_vs, 2);
    chk("R8 vsync high clocks", c_vpin, 20);
    chk("R10 line-active strobes", c_la, 6);
    chk("R10 pixel-active strobes", c_px, 24);

    phase = "R1";
    wr(0, 3, wg(0, 8'h0F, 0));
    @(negedge clk);
    chk("R1 strobes after disable", int'(strobe), 0);
    chk("R1 pins at polarity after disable", int'(pin), 8'h0F);

    phase = "R5";
    wr(5, 0, w0(2, 1, 3, 1)); wr(5, 1, w1(2, 0, 0, 0));   // two periods then halt
    wr(6, 0, w0(0, 1, 0, 1)); wr(6, 1, w1(0, 1, 0, 0));   // cleared every clock
    wr(7, 0, w0(7, 1, 0, 0)); wr(7, 1, w1(0, 0, 1, 1)); wr(7, 2, w2(3, 8));
    wr(0, 3, wg(1, 0, 0));
    c6 = 0; c7 = 0; c8 = 0; c8pin = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      c6 += int'(strobe[5]); c7 += int'(strobe[6]);
      c8 += int'(strobe[7]); c8pin += int'(pin[7]);
    end
    chk("R5 R4 repeat limit strobes", c6, 2);
    chk("R6 clear code 1 silences", c7, 0);
    chk("R5 auto-reload strobes", c8, 10);
    chk("R8 odd up edge window", c8pin, 20);
    finish_run();
  end
endmodule